// File: doc/BRIEF.md
# Byte-Wide Erasable ROM Mode and Command Decoder

This block is the control logic on the device side of a byte-wide, electrically erasable and programmable read-only memory. It watches chip enable, output enable and the program strobe, along with two flags from the analog front end. One flag says the programming supply is present. The other says a high voltage sits on address line 9. It also watches the address bus and the data input bus. From these it decides whether the part is reading, verifying a write, returning an identifier, programming, erasing, or standing by with its outputs released.

Storage is a small register array whose depth is a parameter. A program write can only clear bits, so it ANDs the new byte into the stored byte. Chip erase returns every byte to FF hex. An erase can start in two ways: a strobe pulse while the address-9 high-voltage flag is set, or an unlock sequence of two writes. Chip enable and the program strobe pass through a two-stage synchroniser. Each write or erase takes effect on the falling edge of the synchronised strobe, and the data output and its three-state enable are registered.

Top module: `eprom_ctrl`

## Requirements
- R1: With chip enable high (standby), `dout_en` is 0 whatever the state of output enable and the program strobe.
- R2: A strobe pulse given while chip enable is high changes no stored byte.
- R3: Read mode drives the stored byte onto `dout` with `dout_en` = 1. Read mode is chip enable low, output enable low, strobe high, address-9 flag low and programming supply absent. The word is selected by the low DEPTH_W address bits.
- R4: `dout_en` is 0 when output enable is high. It is also 0 when output enable and the strobe are both low.
- R5: A program write ANDs `din` into the addressed byte, so bits only go from 1 to 0. A program write is a strobe falling edge with chip enable low, output enable high, supply present and the address-9 flag low.
- R6: Program verify drives the stored byte with `dout_en` = 1. It is read mode with the programming supply present.
- R7: A strobe falling edge under program conditions with the address-9 flag set sets every byte to FF hex.
- R8: A program write of AA hex to address 5555 hex, followed directly by a program write of 10 hex to address 2AAA hex, erases the whole array to FF. Addresses are compared on the low 15 bits. Both writes also act as normal program writes.
- R9: The unlock sequence is broken by any write that does not match the expected step, including a repeat of the first step, and by standby. A second-step write after a break erases nothing.
- R10: With chip enable low, output enable low, strobe high and the address-9 flag set, `dout` is DA hex when address bit 0 is 0 and 85 hex when it is 1.
- R11: After reset `dout_en` is 0 and every stored byte reads FF.
- R12: A strobe pulse with the programming supply absent changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low (synchronised inside) |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low (synchronised inside) |
| a9_hv | input | 1 | High voltage present on address line 9 |
| vpp_hi | input | 1 | Programming supply present |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, registered |
| dout_en | output | 1 | Enable for the three-state output buffers, registered |

## Verification
A wrong mode decode shows up as a wrong `dout_en` or `dout` one clock after the synchronised inputs settle. A wrong unlock-detector state stays hidden until the next second-step write. It then shows as an erase that should not happen, or as one that is missing, and the next read of a byte that had been programmed reveals it. The stimulus therefore follows every broken sequence with a complete second step and a readback. An AND that is missing or inverted in the write path shows on the first read after a second write to the same byte.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    localparam int BYTE_W = 8;
    localparam int CMD_W  = 15;

    localparam logic [CMD_W-1:0]  UNLOCK_A1 = 15'h5555;
    localparam logic [BYTE_W-1:0] UNLOCK_D1 = 8'hAA;
    localparam logic [CMD_W-1:0]  UNLOCK_A2 = 15'h2AAA;
    localparam logic [BYTE_W-1:0] UNLOCK_D2 = 8'h10;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_READ,
        MD_VERIFY,
        MD_IDENT,
        MD_QUIET,
        MD_PROGRAM,
        MD_ERASE
    } mode_e;

    typedef enum logic {
        UL_IDLE,
        UL_ARMED
    } unlock_e;

    typedef struct packed {
        logic              pgm_prev;
        logic              dout_en;
        logic [BYTE_W-1:0] dout;
    } ctrl_regs_t;

endpackage

// File: rtl/eprom_sync.sv
module eprom_sync #(
    parameter int         W       = 2,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d    = sh_q;
        sh_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) sh_q[i] <= RST_VAL;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/eprom_unlock.sv
module eprom_unlock
    import eprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_stb,
    input  logic [CMD_W-1:0]  waddr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              fire,
    output logic              armed
);
    unlock_e st_d, st_q;
    logic    step1_hit, step2_hit;

    always_comb begin
        step1_hit = (waddr == UNLOCK_A1) && (wdata == UNLOCK_D1);
        step2_hit = (waddr == UNLOCK_A2) && (wdata == UNLOCK_D2);
        st_d      = st_q;
        fire      = 1'b0;
        if (clear) begin
            st_d = UL_IDLE;
        end else if (wr_stb) begin
            unique case (st_q)
                UL_IDLE:  st_d = step1_hit ? UL_ARMED : UL_IDLE;
                UL_ARMED: begin
                    fire = step2_hit;
                    st_d = UL_IDLE;
                end
                default:  st_d = UL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= UL_IDLE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/eprom_array.sv
module eprom_array
    import eprom_pkg::*;
#(
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               erase_en,
    input  logic [DEPTH_W-1:0] waddr,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [DEPTH_W-1:0] raddr,
    output logic [BYTE_W-1:0]  rdata
);
    localparam int DEPTH = 1 << DEPTH_W;

    logic [BYTE_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [BYTE_W-1:0] word_d;

        always_comb begin
            word_d = mem_q[g];
            if (erase_en) begin
                word_d = '1;
            end else if (wr_en && (waddr == DEPTH_W'(g))) begin
                word_d = mem_q[g] & wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '1;
            else        mem_q[g] <= word_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
    import eprom_pkg::*;
#(
    parameter int              ADDR_W  = 15,
    parameter int              DEPTH_W = 4,
    parameter logic [BYTE_W-1:0] MFR_ID = 8'hDA,
    parameter logic [BYTE_W-1:0] DEV_ID = 8'h85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              a9_hv,
    input  logic              vpp_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_en
);
    logic [1:0]        sync_q;
    logic              ce_s, pgm_s;
    logic              pgm_fall, prog_cond;
    logic              wr_en, erase_en, cmd_fire, armed;
    logic [BYTE_W-1:0] rdata;
    mode_e             mode;
    ctrl_regs_t        st_d, st_q;

    eprom_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, pgm_n}),
        .q     (sync_q)
    );
    assign ce_s  = sync_q[1];
    assign pgm_s = sync_q[0];

    eprom_unlock u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ce_s),
        .wr_stb (wr_en),
        .waddr  (addr[CMD_W-1:0]),
        .wdata  (din),
        .fire   (cmd_fire),
        .armed  (armed)
    );

    eprom_array #(.DEPTH_W(DEPTH_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .erase_en (erase_en),
        .waddr    (addr[DEPTH_W-1:0]),
        .wdata    (din),
        .raddr    (addr[DEPTH_W-1:0]),
        .rdata    (rdata)
    );

    always_comb begin
        // mode selection
        if (ce_s)                 mode = MD_STANDBY;
        else if (!oe_n && pgm_s)  mode = a9_hv  ? MD_IDENT  :
                                         vpp_hi ? MD_VERIFY : MD_READ;
        else if (oe_n && vpp_hi)  mode = a9_hv  ? MD_ERASE  : MD_PROGRAM;
        else                      mode = MD_QUIET;

        pgm_fall  = st_q.pgm_prev && !pgm_s;
        prog_cond = (mode == MD_PROGRAM) || (mode == MD_ERASE);
        wr_en     = pgm_fall && prog_cond && !a9_hv;
        erase_en  = (pgm_fall && prog_cond && a9_hv) || cmd_fire;

        st_d          = st_q;
        st_d.pgm_prev = pgm_s;
        st_d.dout_en  = (mode == MD_READ) || (mode == MD_VERIFY) || (mode == MD_IDENT);
        unique case (mode)
            MD_READ, MD_VERIFY: st_d.dout = rdata;
            MD_IDENT:           st_d.dout = addr[0] ? DEV_ID : MFR_ID;
            default:            st_d.dout = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pgm_prev <= 1'b1;
            st_q.dout_en  <= 1'b0;
            st_q.dout     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.dout;
    assign dout_en = st_q.dout_en;
endmodule

// File: rtl/eprom_ctrl_chk.sv
module eprom_ctrl_chk #(
    parameter logic [7:0] MFR_ID = 8'hDA,
    parameter logic [7:0] DEV_ID = 8'h85
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_s,
    input logic       pgm_s,
    input logic       oe_n,
    input logic       a9_hv,
    input logic       vpp_hi,
    input logic       wr_en,
    input logic       erase_en,
    input logic       armed,
    input logic [7:0] dout,
    input logic       dout_en
);
    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_s |=> !dout_en);

    p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || !pgm_s) |=> !dout_en);

    p_ident_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_s && !oe_n && pgm_s && a9_hv) |=>
            (dout_en && ((dout == MFR_ID) || (dout == DEV_ID))));

    p_write_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || erase_en) |-> (vpp_hi && oe_n && !ce_s));

    p_erase_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> !erase_en);

    p_unlock_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_s |=> !armed);
endmodule

bind eprom_ctrl eprom_ctrl_chk #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s     (ce_s),
    .pgm_s    (pgm_s),
    .oe_n     (oe_n),
    .a9_hv    (a9_hv),
    .vpp_hi   (vpp_hi),
    .wr_en    (wr_en),
    .erase_en (erase_en),
    .armed    (armed),
    .dout     (dout),
    .dout_en  (dout_en)
);

// File: tb/eprom_ctrl_tb.sv
module eprom_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, a9_hv = 1'b0, vpp_hi = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    eprom_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
        .a9_hv(a9_hv), .vpp_hi(vpp_hi), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    typedef struct packed {
        logic        wr;
        logic        ce;
        logic        oe;
        logic        pg;
        logic        vpp;
        logic        hv;
        logic [14:0] a;
        logic [7:0]  d;
        logic        xen;
        logic [7:0]  xd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b1,8'hFF,8'd11}, // R11 erased after reset
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h0003,8'h5A,1'b0,8'h00,8'd5},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b1,8'h5A,8'd3},  // R3 read
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h0003,8'h0F,1'b0,8'h00,8'd5},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b1,8'h0A,8'd5},  // R5 AND
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,15'h0003,8'h00,1'b1,8'h0A,8'd6},  // R6 verify
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,15'h0004,8'h00,1'b0,8'h00,8'd12},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0004,8'h00,1'b1,8'hFF,8'd12}, // R12 no supply
        '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,15'h0004,8'h00,1'b0,8'h00,8'd2},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0004,8'h00,1'b1,8'hFF,8'd2},  // R2 inhibit
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b0,8'h00,8'd1},  // R1 standby
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,15'h0003,8'h00,1'b0,8'h00,8'd1},  // R1 standby strobe low
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b0,8'h00,8'd4},  // R4 oe high
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,15'h0003,8'h00,1'b0,8'h00,8'd4},  // R4 oe and strobe low
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,15'h0000,8'h00,1'b1,8'hDA,8'd10}, // R10 maker
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,15'h0001,8'h00,1'b1,8'h85,8'd10}, // R10 device
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,1'b0,8'h00,8'd7},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b1,8'hFF,8'd7},  // R7 hv erase
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h0003,8'h33,1'b0,8'h00,8'd8},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,8'h00,8'd8},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h2AAA,8'h10,1'b0,8'h00,8'd8},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b1,8'hFF,8'd8},  // R8 unlock erase
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0005,8'h00,1'b1,8'hFF,8'd8},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h0003,8'h33,1'b0,8'h00,8'd9},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,8'h00,8'd9},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h1234,8'h00,1'b0,8'h00,8'd9},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h2AAA,8'h10,1'b0,8'h00,8'd9},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b1,8'h33,8'd9},  // R9 foreign write
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,8'h00,8'd9},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,8'h00,8'd9},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h2AAA,8'h10,1'b0,8'h00,8'd9},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b1,8'h33,8'd9},  // R9 repeated step one
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,8'h00,8'd9},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b0,8'h00,8'd9},  // R9 standby break
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h2AAA,8'h10,1'b0,8'h00,8'd9},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b1,8'h33,8'd9},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,8'h00,8'd8},
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,15'h2AAA,8'h10,1'b0,8'h00,8'd8},
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,15'h0003,8'h00,1'b1,8'hFF,8'd8}   // R8 again
    };

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic c, input logic v, input logic h,
                            input logic [14:0] a, input logic [7:0] d);
        ce_n = c; oe_n = 1'b1; vpp_hi = v; a9_hv = h; addr = a; din = d; pgm_n = 1'b1;
        wait_cyc(4);
        pgm_n = 1'b0;
        wait_cyc(4);
        pgm_n = 1'b1;
        wait_cyc(4);
    endtask

    task automatic do_check(input int tag, input int idx, input logic xen, input logic [7:0] xd);
        n_chk++;
        if ((dout_en !== xen) || (xen && (dout !== xd))) begin
            n_bad++;
            $display("FAIL R%0d step %0d: en=%b dout=%h expected en=%b dout=%h",
                     tag, idx, dout_en, dout, xen, xd);
        end
    endtask

    initial begin
        @(negedge clk);
        wait_cyc(3);
        do_check(11, -1, 1'b0, 8'h00);          // R11 outputs quiet in reset
        rst_n = 1'b1;
        wait_cyc(3);
        do_check(11, -2, 1'b0, 8'h00);          // R11 quiet after release

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                do_write(VEC[i].ce, VEC[i].vpp, VEC[i].hv, VEC[i].a, VEC[i].d);
            end else begin
                ce_n = VEC[i].ce; oe_n = VEC[i].oe; pgm_n = VEC[i].pg;
                vpp_hi = VEC[i].vpp; a9_hv = VEC[i].hv; addr = VEC[i].a; din = VEC[i].d;
                wait_cyc(6);
                do_check(int'(VEC[i].req), i, VEC[i].xen, VEC[i].xd);
            end
        end

        // R5 clearing all bits, then R11 reset restores erased contents
        do_write(1'b0, 1'b1, 1'b0, 15'h0003, 8'h00);
        ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0;
        wait_cyc(6);
        do_check(5, 100, 1'b1, 8'h00);
        rst_n = 1'b0;
        wait_cyc(2);
        do_check(11, 101, 1'b0, 8'h00);
        rst_n = 1'b1;
        wait_cyc(6);
        do_check(11, 102, 1'b1, 8'hFF);

        // R3 address aliasing: high bits ignored by the array
        do_write(1'b0, 1'b1, 1'b0, 15'h0017, 8'hC3);
        ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; addr = 15'h0007;
        wait_cyc(6);
        do_check(3, 103, 1'b1, 8'hC3);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule